// File: doc/BRIEF.md
# Shared Interrupt Best-Pending Scanner

This block keeps, for each of a small set of CPUs, the identity and priority of the most urgent pending shared interrupt. Shared interrupts carry IDs 32 up to NUM_IRQ-1, and shared line `s` of every per-interrupt input vector describes interrupt ID `s+32`. For each interrupt the block is given its state bits, an 8-bit priority (lower value means more urgent) and a target CPU field. A target value of NUM_CPU or more means the interrupt is routed nowhere.

The block does its work in scans that handle one interrupt ID per clock. Eligibility is taken one 32-interrupt word at a time. A *full* command marks every CPU as having nothing pending and then scans all shared IDs. A *ranged* command rescans only a span of IDs against the bests already held. If a CPU's previous winner lies inside that span and nothing in the span beat or matched it, the old result can no longer be trusted. In that case the block chains a full recompute before it reports completion.

Commands use a valid/ready handshake. `cmd_ready` is high only while the block is idle. A source holding `cmd_valid` while `cmd_ready` is low is held off, and it must keep the command fields stable until the clock edge where both are high. `done` pulses for one cycle when a command completes. The per-interrupt inputs should stay stable during a command, apart from the deliberate word-snapshot behaviour described in R10.

Top module: `shared_irq_scan`

## Requirements
- R1: Shared line index `s` of every per-interrupt vector describes interrupt ID `s+32`. A CPU whose best priority is not 0xFF reports an ID in the range 32 to NUM_IRQ-1.
- R2: An interrupt is eligible when all of the following hold: its pending latch is set, or it is level-sensitive (`irq_edge_mode`=0) with its line high; it is enabled; it is not active; and its group is enabled (`irq_group_b`=0 selects `grp_a_en`, 1 selects `grp_b_en`).
- R3: An eligible interrupt whose `irq_target` value is NUM_CPU or more changes no CPU's best. It stays unsignalled.
- R4: An eligible interrupt routed to CPU c replaces c's best in either of two cases: its priority is numerically lower, or its priority is equal and its ID is lower than or equal to the current best ID.
- R5: A full command sets every CPU's best priority to 0xFF and then scans all NUM_IRQ-32 shared IDs. `done` rises NUM_IRQ-32+1 clock edges after the accepting edge.
- R6: A ranged command with first ID F and count K scans only IDs F..F+K-1 against the held bests. Interrupts outside the span do not affect the result. Without a fallback, `done` rises K+1 edges after acceptance.
- R7: After a ranged scan, a full recompute is chained if any CPU meets all three conditions: it was not improved during the scan, its best priority is not 0xFF, and its best ID lies in F..F+K-1. `done` then rises K+NUM_IRQ-32+2 edges after acceptance.
- R8: A ranged command is ignored if F<32, K=0 or F+K>NUM_IRQ. In that case the bests stay unchanged, `done` is high right after the accepting edge, and `cmd_ready` stays high.
- R9: `cmd_ready` is high exactly when idle. `done` lasts one cycle and coincides with `cmd_ready` returning high. After reset every best priority is 0xFF and `done` is low.
- R10: A word's eligibility is captured at the first ID of a scan and at every ID that is a multiple of 32. Input changes inside a word after its capture are not seen by that scan. Changes to a word that has not yet been captured are seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted when valid is also high |
| cmd_full | input | 1 | 1: full recompute, 0: ranged update |
| cmd_first | input | ID_W | First ID of a ranged update |
| cmd_count | input | ID_W+1 | Number of IDs in a ranged update |
| irq_pend_latch | input | NUM_IRQ-32 | Pending latch per shared interrupt |
| irq_edge_mode | input | NUM_IRQ-32 | 1: edge-triggered, 0: level-sensitive |
| irq_line | input | NUM_IRQ-32 | Current input line level |
| irq_enable | input | NUM_IRQ-32 | Enable bit |
| irq_active | input | NUM_IRQ-32 | Active bit |
| irq_group_b | input | NUM_IRQ-32 | Group select (0: A, 1: B) |
| grp_a_en | input | 1 | Group A enable |
| grp_b_en | input | 1 | Group B enable |
| irq_prio | input | (NUM_IRQ-32)*PRIO_W | Priority per shared interrupt |
| irq_target | input | (NUM_IRQ-32)*TGT_W | Target CPU per shared interrupt (>= NUM_CPU: none) |
| best_id | output | NUM_CPU*ID_W | Best pending ID per CPU |
| best_prio | output | NUM_CPU*PRIO_W | Best pending priority per CPU (0xFF: none) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the chained fallback. It needs three things at once: a CPU's earlier winner has stopped being eligible, a later ranged command covers that winner, and nothing inside the span matches or beats it. The bench keeps its own model of every CPU's best. Before issuing ranged commands over random spans, it disables tracked winners on purpose, and directed cases also force the chain with known latency. The word-snapshot rule is reached by changing the inputs in the middle of a command, between the capture of the first word and that of a later one.

// File: rtl/shared_irq_scan_pkg.sv
package shared_irq_scan_pkg;
  localparam int FIRST_SHARED = 32;
  localparam int WORD_BITS    = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_CHECK = 2'd2
  } scan_state_e;
endpackage

// File: rtl/sis_elig_vec.sv
module sis_elig_vec #(
  parameter int NUM_SPI  = 96,
  parameter int PAD_BITS = 128
) (
  input  logic [NUM_SPI-1:0]  pend_latch,
  input  logic [NUM_SPI-1:0]  edge_mode,
  input  logic [NUM_SPI-1:0]  line_lvl,
  input  logic [NUM_SPI-1:0]  enable,
  input  logic [NUM_SPI-1:0]  active,
  input  logic [NUM_SPI-1:0]  group_b,
  input  logic                grp_a_en,
  input  logic                grp_b_en,
  output logic [PAD_BITS-1:0] elig_all
);
  for (genvar i = 0; i < PAD_BITS; i++) begin : g_bit
    if (i < NUM_SPI) begin : g_real
      logic raised;
      logic grp_on;
      assign raised      = pend_latch[i] | (~edge_mode[i] & line_lvl[i]);
      assign grp_on      = group_b[i] ? grp_b_en : grp_a_en;
      assign elig_all[i] = raised & enable[i] & ~active[i] & grp_on;
    end else begin : g_pad
      assign elig_all[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sis_best_table.sv
module sis_best_table #(
  parameter int NUM_CPU = 4,
  parameter int ID_W    = 7,
  parameter int PRIO_W  = 8,
  parameter int TGT_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_all,
  input  logic                      clr_imp,
  input  logic                      upd_vld,
  input  logic [TGT_W-1:0]          upd_tgt,
  input  logic [ID_W-1:0]           upd_id,
  input  logic [PRIO_W-1:0]         upd_prio,
  input  logic [ID_W-1:0]           rng_lo,
  input  logic [ID_W-1:0]           rng_hi,
  output logic [NUM_CPU*ID_W-1:0]   best_id,
  output logic [NUM_CPU*PRIO_W-1:0] best_prio,
  output logic                      need_full
);
  logic [NUM_CPU-1:0] stale;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [ID_W-1:0]   id_q;
    logic [PRIO_W-1:0] pr_q;
    logic              imp_q;
    logic              take;

    assign take = upd_vld && (upd_tgt == TGT_W'(c)) &&
                  ((upd_prio < pr_q) || ((upd_prio == pr_q) && (upd_id <= id_q)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        id_q  <= '0;
        pr_q  <= '1;
        imp_q <= 1'b0;
      end else if (clr_all) begin
        pr_q  <= '1;
        imp_q <= 1'b0;
      end else begin
        if (clr_imp) imp_q <= 1'b0;
        if (take) begin
          id_q  <= upd_id;
          pr_q  <= upd_prio;
          imp_q <= 1'b1;
        end
      end
    end

    assign stale[c] = !imp_q && (pr_q != '1) && (id_q >= rng_lo) && (id_q <= rng_hi);
    assign best_id[c*ID_W +: ID_W]       = id_q;
    assign best_prio[c*PRIO_W +: PRIO_W] = pr_q;
  end

  assign need_full = |stale;
endmodule

// File: rtl/sis_scan_ctrl.sv
module sis_scan_ctrl
  import shared_irq_scan_pkg::*;
#(
  parameter int NUM_IRQ  = 128,
  parameter int ID_W     = 7,
  parameter int PAD_BITS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_full,
  input  logic [ID_W-1:0]     cmd_first,
  input  logic [ID_W:0]       cmd_count,
  input  logic [PAD_BITS-1:0] elig_all,
  input  logic                need_full,
  output logic                scan_vld,
  output logic [ID_W-1:0]     scan_s,
  output logic [ID_W-1:0]     scan_id,
  output logic [ID_W-1:0]     rng_lo,
  output logic [ID_W-1:0]     rng_hi,
  output logic                clr_all,
  output logic                clr_imp,
  output logic                done
);
  localparam int NUM_SPI = NUM_IRQ - FIRST_SHARED;

  scan_state_e          st;
  logic [ID_W-1:0]      cur_q, first_q, last_q;
  logic                 full_q, fresh_q, done_q;
  logic [WORD_BITS-1:0] word_q, word_live;
  logic                 load, cur_bit;
  logic [ID_W+1:0]      cmd_end;
  logic                 rng_ok, accept, go_full, go_range;
  logic [ID_W-1:0]      first_sub, last_calc;

  assign cmd_ready = (st == ST_IDLE);
  assign accept    = cmd_ready && cmd_valid;
  assign cmd_end   = {2'b00, cmd_first} + {1'b0, cmd_count};
  assign rng_ok    = (cmd_first >= ID_W'(FIRST_SHARED)) && (cmd_count != '0) &&
                     (cmd_end <= (ID_W+2)'(NUM_IRQ));
  assign first_sub = cmd_first - ID_W'(FIRST_SHARED);
  assign last_calc = first_sub + cmd_count[ID_W-1:0] - ID_W'(1);

  assign go_full  = (accept && cmd_full) ||
                    ((st == ST_CHECK) && !full_q && need_full);
  assign go_range = accept && !cmd_full && rng_ok;
  assign clr_all  = go_full;
  assign clr_imp  = go_range;

  // eligibility word: live on capture cycles, held copy otherwise
  assign load      = fresh_q || (cur_q[4:0] == 5'd0);
  assign word_live = elig_all[{cur_q[ID_W-1:5], 5'b00000} +: WORD_BITS];
  assign cur_bit   = load ? word_live[cur_q[4:0]] : word_q[cur_q[4:0]];

  assign scan_vld = (st == ST_SCAN) && cur_bit;
  assign scan_s   = cur_q;
  assign scan_id  = cur_q + ID_W'(FIRST_SHARED);
  assign rng_lo   = first_q + ID_W'(FIRST_SHARED);
  assign rng_hi   = last_q + ID_W'(FIRST_SHARED);
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
      full_q  <= 1'b0;
      fresh_q <= 1'b0;
      word_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_full) begin
        st      <= ST_SCAN;
        first_q <= '0;
        last_q  <= ID_W'(NUM_SPI - 1);
        cur_q   <= '0;
        full_q  <= 1'b1;
        fresh_q <= 1'b1;
      end else if (go_range) begin
        st      <= ST_SCAN;
        first_q <= first_sub;
        last_q  <= last_calc;
        cur_q   <= first_sub;
        full_q  <= 1'b0;
        fresh_q <= 1'b1;
      end else begin
        case (st)
          ST_IDLE: begin
            if (accept) done_q <= 1'b1;   // rejected range
          end
          ST_SCAN: begin
            fresh_q <= 1'b0;
            if (load) word_q <= word_live;
            cur_q <= cur_q + ID_W'(1);
            if (cur_q == last_q) st <= ST_CHECK;
          end
          ST_CHECK: begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/shared_irq_scan.sv
module shared_irq_scan
  import shared_irq_scan_pkg::*;
#(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 8,
  localparam int ID_W     = $clog2(NUM_IRQ),
  localparam int NUM_SPI  = NUM_IRQ - 32,
  localparam int TGT_W    = $clog2(NUM_CPU + 1),
  localparam int PAD_BITS = 1 << ID_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic                      cmd_full,
  input  logic [ID_W-1:0]           cmd_first,
  input  logic [ID_W:0]             cmd_count,
  input  logic [NUM_SPI-1:0]        irq_pend_latch,
  input  logic [NUM_SPI-1:0]        irq_edge_mode,
  input  logic [NUM_SPI-1:0]        irq_line,
  input  logic [NUM_SPI-1:0]        irq_enable,
  input  logic [NUM_SPI-1:0]        irq_active,
  input  logic [NUM_SPI-1:0]        irq_group_b,
  input  logic                      grp_a_en,
  input  logic                      grp_b_en,
  input  logic [NUM_SPI*PRIO_W-1:0] irq_prio,
  input  logic [NUM_SPI*TGT_W-1:0]  irq_target,
  output logic [NUM_CPU*ID_W-1:0]   best_id,
  output logic [NUM_CPU*PRIO_W-1:0] best_prio,
  output logic                      done
);
  logic [PAD_BITS-1:0] elig_all;
  logic                need_full, scan_vld, clr_all, clr_imp;
  logic [ID_W-1:0]     scan_s, scan_id, rng_lo, rng_hi;
  logic [PRIO_W-1:0]   sel_prio;
  logic [TGT_W-1:0]    sel_tgt;
  logic                routed;

  sis_elig_vec #(.NUM_SPI(NUM_SPI), .PAD_BITS(PAD_BITS)) elig_i (
    .pend_latch (irq_pend_latch),
    .edge_mode  (irq_edge_mode),
    .line_lvl   (irq_line),
    .enable     (irq_enable),
    .active     (irq_active),
    .group_b    (irq_group_b),
    .grp_a_en   (grp_a_en),
    .grp_b_en   (grp_b_en),
    .elig_all   (elig_all)
  );

  sis_scan_ctrl #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W), .PAD_BITS(PAD_BITS)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_full  (cmd_full),
    .cmd_first (cmd_first),
    .cmd_count (cmd_count),
    .elig_all  (elig_all),
    .need_full (need_full),
    .scan_vld  (scan_vld),
    .scan_s    (scan_s),
    .scan_id   (scan_id),
    .rng_lo    (rng_lo),
    .rng_hi    (rng_hi),
    .clr_all   (clr_all),
    .clr_imp   (clr_imp),
    .done      (done)
  );

  // pick priority and target of the interrupt under scan
  always_comb begin
    sel_prio = '0;
    sel_tgt  = '0;
    for (int i = 0; i < NUM_SPI; i++) begin
      if (scan_s == ID_W'(i)) begin
        sel_prio = irq_prio[i*PRIO_W +: PRIO_W];
        sel_tgt  = irq_target[i*TGT_W +: TGT_W];
      end
    end
  end

  assign routed = scan_vld && (sel_tgt < TGT_W'(NUM_CPU));

  sis_best_table #(.NUM_CPU(NUM_CPU), .ID_W(ID_W), .PRIO_W(PRIO_W), .TGT_W(TGT_W)) table_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (clr_all),
    .clr_imp   (clr_imp),
    .upd_vld   (routed),
    .upd_tgt   (sel_tgt),
    .upd_id    (scan_id),
    .upd_prio  (sel_prio),
    .rng_lo    (rng_lo),
    .rng_hi    (rng_hi),
    .best_id   (best_id),
    .best_prio (best_prio),
    .need_full (need_full)
  );
endmodule

// File: rtl/shared_irq_scan_chk.sv
module shared_irq_scan_chk #(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 8,
  localparam int ID_W   = $clog2(NUM_IRQ)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmd_valid,
  input logic                      cmd_ready,
  input logic                      cmd_full,
  input logic [ID_W-1:0]           cmd_first,
  input logic [ID_W:0]             cmd_count,
  input logic [NUM_CPU*ID_W-1:0]   best_id,
  input logic [NUM_CPU*PRIO_W-1:0] best_prio,
  input logic                      done
);
  logic [ID_W+1:0] end_c;
  logic            bad_rng, acc;
  assign end_c   = {2'b00, cmd_first} + {1'b0, cmd_count};
  assign bad_rng = (cmd_first < ID_W'(32)) || (cmd_count == '0) || (end_c > (ID_W+2)'(NUM_IRQ));
  assign acc     = cmd_valid && cmd_ready;

  a_r9_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !acc) |=> !done);

  a_r8_bad_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cmd_full && bad_rng) |=> (done && cmd_ready && $stable(best_prio) && $stable(best_id)));

  a_r5_full_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_full) |=> !cmd_ready);

  a_r6_idle_holds_bests: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> ($stable(best_id) && $stable(best_prio)));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    a_r1_id_in_shared_span: assert property (@(posedge clk) disable iff (!rst_n)
      (best_prio[c*PRIO_W +: PRIO_W] != '1) |->
        ((best_id[c*ID_W +: ID_W] >= ID_W'(32)) && ({1'b0, best_id[c*ID_W +: ID_W]} < (ID_W+1)'(NUM_IRQ))));
  end
endmodule

bind shared_irq_scan shared_irq_scan_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_full  (cmd_full),
  .cmd_first (cmd_first),
  .cmd_count (cmd_count),
  .best_id   (best_id),
  .best_prio (best_prio),
  .done      (done)
);

// File: tb/shared_irq_scan_tb_top.sv
module shared_irq_scan_tb_top;
  localparam int NUM_IRQ = 128;
  localparam int NUM_CPU = 4;
  localparam int PRIO_W  = 8;
  localparam int ID_W    = 7;
  localparam int NUM_SPI = NUM_IRQ - 32;
  localparam int TGT_W   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_full = 1'b0;
  logic [ID_W-1:0] cmd_first = '0;
  logic [ID_W:0]   cmd_count = '0;
  logic cmd_ready, done;
  logic [NUM_SPI-1:0] irq_pend_latch = '0, irq_edge_mode = '0, irq_line = '0;
  logic [NUM_SPI-1:0] irq_enable = '0, irq_active = '0, irq_group_b = '0;
  logic grp_a_en = 1'b1, grp_b_en = 1'b1;
  logic [NUM_SPI*PRIO_W-1:0] irq_prio = '0;
  logic [NUM_SPI*TGT_W-1:0]  irq_target = '0;
  logic [NUM_CPU*ID_W-1:0]   best_id;
  logic [NUM_CPU*PRIO_W-1:0] best_prio;

  int n_checks = 0, n_errors = 0;
  bit finished = 0;
  int m_id[NUM_CPU], m_pr[NUM_CPU];

  always #2 clk = ~clk;

  shared_irq_scan #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)) dut_i (.*);

  task automatic check_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit elig(input int s);
    bit grp_on = irq_group_b[s] ? grp_b_en : grp_a_en;
    return (irq_pend_latch[s] | (~irq_edge_mode[s] & irq_line[s])) &
           irq_enable[s] & ~irq_active[s] & grp_on;
  endfunction

  task automatic model_scan(input int lo, input int hi, inout bit imp[NUM_CPU]);
    for (int s = lo; s <= hi; s++) begin
      int t = int'(irq_target[s*TGT_W +: TGT_W]);
      int p = int'(irq_prio[s*PRIO_W +: PRIO_W]);
      if (elig(s) && t < NUM_CPU) begin
        if (p < m_pr[t] || (p == m_pr[t] && s + 32 <= m_id[t])) begin
          m_pr[t] = p; m_id[t] = s + 32; imp[t] = 1;
        end
      end
    end
  endtask

  task automatic model_cmd(input bit full, input int first, input int count, output int lat);
    bit imp[NUM_CPU];
    bit chain = 0;
    for (int c = 0; c < NUM_CPU; c++) imp[c] = 0;
    if (full) begin
      for (int c = 0; c < NUM_CPU; c++) m_pr[c] = 255;
      model_scan(0, NUM_SPI - 1, imp);
      lat = NUM_SPI + 1;
    end else if (first < 32 || count == 0 || first + count > NUM_IRQ) begin
      lat = 0;
    end else begin
      model_scan(first - 32, first - 32 + count - 1, imp);
      lat = count + 1;
      for (int c = 0; c < NUM_CPU; c++)
        if (!imp[c] && m_pr[c] != 255 && m_id[c] >= first && m_id[c] <= first + count - 1)
          chain = 1;
      if (chain) begin
        for (int c = 0; c < NUM_CPU; c++) begin m_pr[c] = 255; imp[c] = 0; end
        model_scan(0, NUM_SPI - 1, imp);
        lat += NUM_SPI + 1;
      end
    end
  endtask

  task automatic drive_cmd(input bit full, input int first, input int count);
    @(negedge clk);
    cmd_valid = 1; cmd_full = full;
    cmd_first = ID_W'(first); cmd_count = (ID_W+1)'(count);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 400) begin
      @(posedge clk); lat++; @(negedge clk);
    end
  endtask

  task automatic check_bests(input string tag);
    for (int c = 0; c < NUM_CPU; c++) begin
      check_eq($sformatf("%s prio cpu%0d", tag, c), int'(best_prio[c*PRIO_W +: PRIO_W]), m_pr[c]);
      if (m_pr[c] != 255)
        check_eq($sformatf("%s id cpu%0d", tag, c), int'(best_id[c*ID_W +: ID_W]), m_id[c]);
    end
  endtask

  task automatic run_cmd(input string tag, input bit full, input int first, input int count);
    int exp_lat, lat;
    model_cmd(full, first, count, exp_lat);
    drive_cmd(full, first, count);
    wait_done(lat);
    check_eq({tag, " latency"}, lat, exp_lat);
    check_eq({tag, " R9 ready with done"}, int'(cmd_ready), 1);
    check_bests(tag);
  endtask

  task automatic set_irq(input int s, input bit en, input int p, input int t);
    irq_pend_latch[s] = 1; irq_edge_mode[s] = 1; irq_line[s] = 0;
    irq_enable[s] = en; irq_active[s] = 0; irq_group_b[s] = 0;
    irq_prio[s*PRIO_W +: PRIO_W] = PRIO_W'(p);
    irq_target[s*TGT_W +: TGT_W] = TGT_W'(t);
  endtask

  task automatic clear_cfg();
    irq_pend_latch = '0; irq_edge_mode = '0; irq_line = '0;
    irq_enable = '0; irq_active = '0; irq_group_b = '0;
    grp_a_en = 1; grp_b_en = 1;
  endtask

  task automatic random_cfg();
    for (int s = 0; s < NUM_SPI; s++) begin
      int pk = int'($urandom % 5);
      irq_pend_latch[s] = ($urandom % 4 == 0);
      irq_edge_mode[s]  = $urandom % 2;
      irq_line[s]       = $urandom % 2;
      irq_enable[s]     = ($urandom % 3 == 0);
      irq_active[s]     = ($urandom % 6 == 0);
      irq_group_b[s]    = $urandom % 2;
      irq_prio[s*PRIO_W +: PRIO_W] = (pk == 4) ? 8'hFF : PRIO_W'(16 * (pk + 1));
      irq_target[s*TGT_W +: TGT_W] = TGT_W'($urandom % 6);
    end
    grp_a_en = ($urandom % 5 != 0);
    grp_b_en = ($urandom % 5 != 0);
  endtask

  initial begin
    int lat;
    void'($urandom(32'd20240611));
    for (int c = 0; c < NUM_CPU; c++) begin m_id[c] = 0; m_pr[c] = 255; end
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R9: reset state
    check_eq("R9 reset ready", int'(cmd_ready), 1);
    check_eq("R9 reset done", int'(done), 0);
    check_bests("R9 reset");

    // R1 / R5: single interrupt line 0 -> ID 32 on cpu2
    clear_cfg();
    set_irq(0, 1, 8'h40, 2);
    run_cmd("R1 R5 full single", 1, 0, 0);
    check_eq("R1 line0 maps to ID32", int'(best_id[2*ID_W +: ID_W]), 32);

    // R2: level-sensitive line, group B
    clear_cfg();
    irq_line[5] = 1; irq_enable[5] = 1; irq_group_b[5] = 1;
    irq_prio[5*PRIO_W +: PRIO_W] = 8'h10; irq_target[5*TGT_W +: TGT_W] = 3'd1;
    grp_b_en = 0;
    run_cmd("R2 group off", 1, 0, 0);
    check_eq("R2 group disabled hides", int'(best_prio[1*PRIO_W +: PRIO_W]), 255);
    grp_b_en = 1;
    run_cmd("R2 group on", 1, 0, 0);
    check_eq("R2 level line seen", int'(best_id[1*ID_W +: ID_W]), 37);
    irq_active[5] = 1;
    run_cmd("R2 active hides", 1, 0, 0);
    irq_active[5] = 0; irq_edge_mode[5] = 1;
    run_cmd("R2 edge without latch", 1, 0, 0);
    check_eq("R2 edge line alone hides", int'(best_prio[1*PRIO_W +: PRIO_W]), 255);

    // R3: unrouted interrupt
    clear_cfg();
    set_irq(10, 1, 8'h01, 5);
    set_irq(11, 1, 8'h30, 0);
    run_cmd("R3 no target", 1, 0, 0);
    check_eq("R3 cpu0 keeps routed one", int'(best_id[0 +: ID_W]), 43);

    // R4: tie on priority
    clear_cfg();
    set_irq(20, 1, 8'h20, 3);
    set_irq(30, 1, 8'h20, 3);
    run_cmd("R4 tie full", 1, 0, 0);
    check_eq("R4 tie lower id wins", int'(best_id[3*ID_W +: ID_W]), 52);
    run_cmd("R4 higher id no replace", 0, 62, 1);
    run_cmd("R4 same id rewins", 0, 52, 1);

    // R7: previous winner drops out inside range
    irq_enable[20] = 0;
    run_cmd("R7 chained full", 0, 52, 1);
    check_eq("R7 new winner", int'(best_id[3*ID_W +: ID_W]), 62);

    // R6: better interrupt outside range not seen
    set_irq(90, 1, 8'h01, 3);
    run_cmd("R6 out of range", 0, 52, 9);
    check_eq("R6 cpu3 unchanged", int'(best_id[3*ID_W +: ID_W]), 62);

    // R8: rejected ranges
    run_cmd("R8 first below 32", 0, 10, 5);
    run_cmd("R8 zero count", 0, 40, 0);
    run_cmd("R8 past end", 0, 120, 20);

    // R10: word capture
    clear_cfg();
    for (int c = 0; c < NUM_CPU; c++) m_pr[c] = 255;
    set_irq(8, 0, 8'h05, 0);
    set_irq(38, 1, 8'h50, 0);
    run_cmd("R10 setup", 1, 0, 0);
    drive_cmd(0, 32, 64);          // accepted; first word captured on next edge
    @(posedge clk); @(negedge clk);
    irq_enable[8] = 1;             // word 0 already captured
    set_irq(40, 1, 8'h04, 1);      // word 1 not yet captured
    wait_done(lat);
    check_eq("R10 latency", lat, 64);
    check_eq("R10 captured word ignores late change", int'(best_id[0 +: ID_W]), 70);
    check_eq("R10 later word sees change", int'(best_id[1*ID_W +: ID_W]), 72);
    m_id[0] = 70; m_pr[0] = 8'h50; m_id[1] = 72; m_pr[1] = 8'h04;
    run_cmd("R10 full afterwards", 1, 0, 0);

    // random phase: R4 R6 R7
    random_cfg();
    run_cmd("R5 random full", 1, 0, 0);
    for (int k = 0; k < 60; k++) begin
      int first, count;
      if ($urandom % 3 == 0) random_cfg();
      for (int c = 0; c < NUM_CPU; c++)
        if (m_pr[c] != 255 && $urandom % 2 == 0) irq_enable[m_id[c] - 32] = 0;
      if ($urandom % 8 == 0) begin
        run_cmd($sformatf("R5 rnd%0d full", k), 1, 0, 0);
      end else begin
        first = 32 + int'($urandom % NUM_SPI);
        count = 1 + int'($urandom % (NUM_IRQ - first));
        if ($urandom % 10 == 0) count = 0;
        run_cmd($sformatf("R6 R7 rnd%0d ranged %0d+%0d", k, first, count), 0, first, count);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule